// File: doc/BRIEF.md
# Dual-Source Baud Tick Generator

This block makes the rate enable for a serial port. Software writes one configuration word. The word holds a divisor, an enable flag and a source select. The block then sends out a one-cycle `tick` at a fixed fraction of the clock. The transmit and receive engines advance only on cycles where `tick` is high, so they need no divided clock of their own.

There are two counting paths.

- **Direct path:** every enabled clock cycle feeds the divisor counter. The stored divisor is the wanted division ratio minus one. Software usually programs a ratio that makes `tick` run at four times the line rate.
- **Prescaled path:** a fixed divide-by-three stage sits in front of the divisor counter. This suits a crystal reference, where the ratio is the clock divided by three and then by the baud rate.

The host keeps the usable line rates between 50 and 4,000,000 baud. A clock-enable input stalls all counting, so the block can run from a fast system clock that is gated by a slower strobe. Every configuration write restarts both counters. The first tick at the new rate therefore comes exactly one full period after the write.

Top module: `serial_rate_tick`

## Requirements
- R1: After reset, `tick` is low and the enable flag is clear, so no tick appears until a configuration word with the enable flag set has been written.
- R2: The configuration word is decoded as follows: bits DIV_W-1:0 are the divisor D, bit DIV_W is the enable flag, and bit DIV_W+1 is the source select (0 = direct, 1 = divide-by-three first). With the default DIV_W of 23 these are bits 22:0, bit 23 and bit 24.
- R3: While the enable flag is clear, `tick` stays low whatever the divisor, the source select and `clk_en` are.
- R4: On the direct path, `tick` is high after every (D+1)-th enabled clock edge counted from the write.
- R5: On the prescaled path, `tick` is high after every 3*(D+1)-th enabled clock edge counted from the write.
- R6: When the ratio is above one, each tick lasts exactly one cycle. With D = 0 on the direct path, `tick` stays high on every enabled cycle.
- R7: An edge at which `clk_en` is low advances no counter, and `tick` is low in the cycle after it.
- R8: The edge that takes a configuration write clears `tick` and restarts both counters. The next tick follows a full period after the write, whatever phase the old setting was in.
- R9: The largest divisor (all ones) gives a ratio of 2^DIV_W on the direct path and 3*2^DIV_W on the prescaled path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Count enable; counters advance only on edges where it is high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | DIV_W+2 | Configuration word: divisor, enable flag, source select |
| tick | output | 1 | One-cycle rate enable for the serial engines |

## Verification
The bench builds the block with DIV_W = 8 and keeps the fixed divide-by-three stage. With this width an all-ones divisor has a period of only 256 or 768 enabled cycles. That brings the full-range reload (R9) and the counter wrap at the top of the range within a short run, on both paths. Randomly gated `clk_en` patterns and writes made in the middle of a period exercise the stall and restart rules, and each cycle is compared with a count of enabled edges kept in the bench.

// File: rtl/rate_pkg.sv
package rate_pkg;

    // Source select encoding for the configuration word
    typedef enum logic {
        SRC_DIRECT = 1'b0,
        SRC_DIV3   = 1'b1
    } rate_src_e;

    // Fixed ratio of the prescale stage on the crystal path
    localparam int PRESCALE_RATIO = 3;

endpackage

// File: rtl/rate_cfg_reg.sv
module rate_cfg_reg
    import rate_pkg::*;
#(
    parameter int DIV_W = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DIV_W+1:0]     wr_data,
    output logic [DIV_W-1:0]     div_o,
    output logic                 use_o,
    output rate_src_e            src_o
);

    localparam int USE_BIT = DIV_W;
    localparam int SRC_BIT = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             use_f;
        rate_src_e        src;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.div   = wr_data[DIV_W-1:0];
            st_d.use_f = wr_data[USE_BIT];
            st_d.src   = rate_src_e'(wr_data[SRC_BIT]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{div: '0, use_f: 1'b0, src: SRC_DIRECT};
        end else begin
            st_q <= st_d;
        end
    end

    assign div_o = st_q.div;
    assign use_o = st_q.use_f;
    assign src_o = st_q.src;

endmodule

// File: rtl/rate_prescale.sv
module rate_prescale
    import rate_pkg::*;
#(
    parameter int RATIO = PRESCALE_RATIO
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      enable,
    input  rate_src_e src,
    input  logic      clk_en,
    output logic      strobe
);

    logic run;
    assign run = enable && clk_en && !restart;

    generate
        if (RATIO > 1) begin : g_div
            localparam int CW = $clog2(RATIO);
            localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

            typedef struct packed {
                logic [CW-1:0] pcnt;
            } pre_t;

            pre_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (restart) begin
                    st_d.pcnt = '0;
                end else if (run && (src == SRC_DIV3)) begin
                    st_d.pcnt = (st_q.pcnt == LAST) ? '0 : st_q.pcnt + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '{pcnt: '0};
                end else begin
                    st_q <= st_d;
                end
            end

            assign strobe = run && ((src == SRC_DIRECT) || (st_q.pcnt == LAST));
        end else begin : g_pass
            logic unused_src;
            assign unused_src = src[0] ^ clk ^ rst_n;
            assign strobe = run;
        end
    endgenerate

endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
    parameter int DIV_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] div,
    input  logic             strobe,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } divc_t;

    divc_t st_d, st_q;
    logic  at_zero;

    assign at_zero = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt  = load_val;
            st_d.tick = 1'b0;
        end else begin
            st_d.tick = strobe && at_zero;
            if (strobe) begin
                st_d.cnt = at_zero ? div : st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, tick: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

endmodule

// File: rtl/serial_rate_tick.sv
module serial_rate_tick
    import rate_pkg::*;
#(
    parameter int DIV_W    = 23,
    parameter int PRESCALE = PRESCALE_RATIO
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             cfg_we,
    input  logic [DIV_W+1:0] cfg_wdata,
    output logic             tick
);

    logic [DIV_W-1:0] cfg_div;
    logic             cfg_use;
    rate_src_e        cfg_src;
    logic             pre_strobe;

    rate_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .div_o   (cfg_div),
        .use_o   (cfg_use),
        .src_o   (cfg_src)
    );

    rate_prescale #(.RATIO(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_we),
        .enable  (cfg_use),
        .src     (cfg_src),
        .clk_en  (clk_en),
        .strobe  (pre_strobe)
    );

    rate_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cfg_we),
        .load_val (cfg_wdata[DIV_W-1:0]),
        .div      (cfg_div),
        .strobe   (pre_strobe),
        .tick     (tick)
    );

endmodule

// File: rtl/rate_tick_checker.sv
module rate_tick_checker #(
    parameter int DIV_W = 23
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             cfg_we,
    input logic             tick,
    input logic             use_q,
    input logic             src_q,
    input logic [DIV_W-1:0] div_q
);

    AST_TICK_NEEDS_USE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> use_q); // R3

    AST_IDLE_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_q && !cfg_we) |=> !tick); // R1

    AST_STALL_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> !tick); // R7

    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !tick); // R8

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (src_q || (div_q != '0))) |=> !tick); // R6

endmodule

bind serial_rate_tick rate_tick_checker #(.DIV_W(DIV_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_en (clk_en),
    .cfg_we (cfg_we),
    .tick   (tick),
    .use_q  (cfg_use),
    .src_q  (cfg_src),
    .div_q  (cfg_div)
);

// File: tb/sim_serial_rate_tick.sv
`timescale 1ns/1ps
module sim_serial_rate_tick;

    localparam int DIV_W = 8;
    localparam int DMAX  = (1 << DIV_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_en = 1'b0;
    logic             cfg_we = 1'b0;
    logic [DIV_W+1:0] cfg_wdata = '0;
    logic             tick;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_rate_tick #(.DIV_W(DIV_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tick      (tick)
    );

    function automatic int ratio_of(input int dv, input bit sl);
        return (sl ? 3 : 1) * (dv + 1);
    endfunction

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: tick=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Writes a configuration, then checks every following cycle against the
    // count of enabled edges since the write edge.
    task automatic run_cfg(input int dv, input bit us, input bit sl,
                           input int cycles, input int en_pct, input string tag);
        int n;
        int cnt;
        bit en;
        bit exp;
        n = ratio_of(dv, sl);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {sl, us, dv[DIV_W-1:0]};
        clk_en    = 1'($urandom);
        @(negedge clk);
        cfg_we = 1'b0;
        check(tick, 1'b0, "R8 write edge");
        cnt = 0;
        for (int k = 0; k < cycles; k++) begin
            en = ($urandom_range(99) < en_pct);
            clk_en = en;
            @(negedge clk);
            if (en) cnt++;
            exp = us && en && ((cnt % n) == 0);
            check(tick, exp, tag);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        clk_en = 1'b1;
        repeat (3) @(negedge clk);
        check(tick, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(tick, 1'b0, "R1 after reset");
        end

        // R3: enable flag clear
        run_cfg(0, 1'b0, 1'b0, 60, 100, "R3 disabled direct");
        run_cfg(2, 1'b0, 1'b1, 60, 70, "R3 disabled prescaled");
        // R2 field decode and R4 direct path
        run_cfg(0, 1'b1, 1'b0, 30, 100, "R6 ratio one");
        run_cfg(1, 1'b1, 1'b0, 40, 100, "R4 direct D=1");
        run_cfg(5, 1'b1, 1'b0, 60, 100, "R4 direct D=5");
        // R5 prescaled path
        run_cfg(0, 1'b1, 1'b1, 40, 100, "R5 prescaled D=0");
        run_cfg(2, 1'b1, 1'b1, 60, 100, "R5 prescaled D=2");
        // R7 gated clock enable
        run_cfg(3, 1'b1, 1'b0, 200, 50, "R7 direct gated");
        run_cfg(1, 1'b1, 1'b1, 200, 40, "R7 prescaled gated");
        // R8 restart mid-period: same setting written again partway through
        run_cfg(9, 1'b1, 1'b0, 14, 100, "R8 first phase");
        run_cfg(9, 1'b1, 1'b0, 40, 100, "R8 restarted phase");
        run_cfg(4, 1'b1, 1'b1, 7, 100, "R8 prescaled partial");
        run_cfg(6, 1'b1, 1'b0, 30, 100, "R8 new setting");
        // R9 full-range divisor
        run_cfg(DMAX, 1'b1, 1'b0, 2 * (DMAX + 1) + 8, 100, "R9 direct max");
        run_cfg(DMAX, 1'b1, 1'b1, 2 * 3 * (DMAX + 1) + 8, 100, "R9 prescaled max");
        // Random configurations
        for (int r = 0; r < 24; r++) begin
            int dv;
            bit us;
            bit sl;
            int pct;
            dv  = $urandom_range(20);
            us  = ($urandom_range(7) != 0);
            sl  = 1'($urandom);
            pct = 30 + $urandom_range(70);
            run_cfg(dv, us, sl, 120, pct, "R2 random config");
        end
        // R3: flag cleared after active operation
        run_cfg(0, 1'b0, 1'b0, 40, 100, "R3 cleared again");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule